// File: doc/BRIEF.md
# Isochronous Split OUT Position Sequencer

This block runs the start-split side of a full-speed isochronous OUT transfer that a high-speed host sends through a hub's transaction translator. Software activates a descriptor once with four values: a start-split micro-frame mask, a transaction count, a first position code and the total payload length. The block holds these values until the sequence ends. On each micro-frame tick it decides whether a start-split goes out. When one does, it cuts the next piece of the payload and tags that piece with a position code. The translator uses the code to rebuild the full packet.

Each issued piece is shown for one cycle on a valid output, together with its byte offset, its length and its position code. The consumer must hold the ready input high during the tick cycle. If ready is low at a scheduled slot, or if the sequence would run across a frame boundary, the block pulses a missed flag. It then drops the sequence and does not try to fill it in later. Activation is refused when the masks would put a start-split and a complete-split into micro-frame 1 of the same frame.

Top module: `iso_split_seq`

## Requirements
- R1: The piece issued as the k-th start-split (k counted from 0) has byte offset 188*k and length min(188, total length - 188*k).
- R2: Position codes are 2 bits: 00 all, 01 begin, 10 mid, 11 end. The first piece carries the loaded code. After begin or mid, the next code is mid while more than one transaction remains, otherwise end. A sequence that starts with all keeps the code all.
- R3: A start-split is issued only on a tick whose micro-frame index selects a set bit in the loaded mask. out_valid is high for exactly the cycle after that tick.
- R4: The transaction count goes down by one on every issued piece. `active` falls in the cycle after the piece that brings the count to zero.
- R5: A zero-length payload loaded with code all is sent as a single piece with length 0 and code 00.
- R6: If a scheduled slot comes while out_ready is low, `missed` pulses the cycle after, `active` falls and no later piece is issued. If out_ready is low on an unscheduled tick, nothing happens.
- R7: A tick at micro-frame 0 while a started sequence is still active ends the sequence with a `missed` pulse and no piece, even if mask bit 0 is set.
- R8: An activation is refused and `active` stays low when the transaction count is 0, or when bit 1 is set in both the start-split mask and the complete-split mask.
- R9: An activation while `active` is high is ignored. The sequence in progress keeps its loaded values.
- R10: After reset, `active`, `out_valid` and `missed` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uf_tick | input | 1 | One-cycle pulse at the start of each micro-frame |
| uf_idx | input | 3 | Micro-frame index within the frame (0..7) |
| act_req | input | 1 | Pulse to load and activate the descriptor |
| ss_mask | input | 8 | Start-split micro-frame mask, bit i selects micro-frame i |
| cs_mask | input | 8 | Complete-split micro-frame mask, used only for the micro-frame 1 check |
| tcnt_init | input | 3 | Number of start-splits in the sequence |
| tpos_init | input | 2 | First position code (00 all, 01 begin) |
| total_len | input | 11 | Total OUT payload length in bytes |
| out_ready | input | 1 | Consumer can take a piece; sampled in the tick cycle |
| out_valid | output | 1 | A piece is issued this cycle |
| out_off | output | 11 | Byte offset of the piece |
| out_len | output | 8 | Length of the piece in bytes |
| out_pos | output | 2 | Position code of the piece |
| missed | output | 1 | One-cycle pulse when a slot was lost or the frame boundary was reached |
| active | output | 1 | Descriptor is active |

## Verification
Two things can land on the same tick: a scheduled slot at micro-frame 0 and the frame-boundary end of a sequence that has already started. The bench sets up this case with mask bits 7 and 0 both set, a two-piece payload and a tick at micro-frame 7 followed by one at micro-frame 0. The expected result is a missed pulse with no valid piece and `active` low. A second overlap is an activation request while the last piece of a sequence is still pending. That request must have no effect on the offsets and lengths that follow.

// File: rtl/iso_split_pkg.sv
package iso_split_pkg;

  typedef enum logic [1:0] {
    POS_ALL   = 2'b00,
    POS_BEGIN = 2'b01,
    POS_MID   = 2'b10,
    POS_END   = 2'b11
  } pos_e;

endpackage

// File: rtl/iso_split_chunk.sv
module iso_split_chunk
  import iso_split_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 3,
  parameter int CHUNK_MAX = 188,
  parameter int CLEN_W    = 8
) (
  input  logic [LEN_W-1:0]  total_q,
  input  logic [LEN_W-1:0]  off_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  pos_e              pos_q,
  output logic [LEN_W-1:0]  step,
  output logic [CLEN_W-1:0] len,
  output pos_e              pos_next
);

  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_MAX);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [LEN_W-1:0] remain;
  logic [CNT_W-1:0] cnt_left;

  // Bytes still to send, clipped to one start-split payload
  always_comb begin
    remain = total_q - off_q;
    if (remain > CHUNK_L) begin
      step = CHUNK_L;
    end else begin
      step = remain;
    end
    len = step[CLEN_W-1:0];
  end

  // Code for the piece that follows the current one
  always_comb begin
    cnt_left = cnt_q - ONE_C;
    if (pos_q == POS_ALL) begin
      pos_next = POS_ALL;
    end else if (cnt_left > ONE_C) begin
      pos_next = POS_MID;
    end else begin
      pos_next = POS_END;
    end
  end

endmodule

// File: rtl/iso_split_desc.sv
module iso_split_desc
  import iso_split_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 3,
  parameter int UF_N  = 8,
  parameter int UF_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_tick,
  input  logic [UF_W-1:0]  uf_idx,
  input  logic             act_req,
  input  logic [UF_N-1:0]  ss_mask,
  input  logic [UF_N-1:0]  cs_mask,
  input  logic [CNT_W-1:0] tcnt_init,
  input  logic [1:0]       tpos_init,
  input  logic [LEN_W-1:0] total_len,
  input  logic             out_ready,
  input  logic [LEN_W-1:0] step,
  input  pos_e             pos_next,
  output logic             active_q,
  output logic [CNT_W-1:0] cnt_q,
  output pos_e             pos_q,
  output logic [LEN_W-1:0] off_q,
  output logic [LEN_W-1:0] total_q,
  output logic [UF_N-1:0]  mask_q,
  output logic             issue,
  output logic             miss
);

  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO_C = '0;

  logic             started_q;
  logic             active_d;
  logic             started_d;
  logic [CNT_W-1:0] cnt_d;
  pos_e             pos_d;
  logic [LEN_W-1:0] off_d;
  logic             load_en;
  logic             adv_en;
  logic             slot;
  logic             boundary;
  logic             uf1_clash;

  always_comb begin
    slot      = uf_tick && active_q && mask_q[uf_idx];
    boundary  = uf_tick && active_q && started_q && (uf_idx == '0);
    uf1_clash = ss_mask[1] && cs_mask[1];
    load_en   = act_req && !active_q && (tcnt_init != ZERO_C) && !uf1_clash;
    adv_en    = 1'b0;
    issue     = 1'b0;
    miss      = 1'b0;
    active_d  = active_q;
    started_d = started_q;
    cnt_d     = cnt_q;
    pos_d     = pos_q;
    off_d     = off_q;
    if (boundary) begin
      miss     = 1'b1;
      active_d = 1'b0;
    end else if (slot) begin
      if (out_ready) begin
        issue     = 1'b1;
        adv_en    = 1'b1;
        cnt_d     = cnt_q - ONE_C;
        off_d     = off_q + step;
        pos_d     = pos_next;
        started_d = 1'b1;
        if (cnt_q == ONE_C) begin
          active_d = 1'b0;
        end
      end else begin
        miss     = 1'b1;
        active_d = 1'b0;
      end
    end else if (load_en) begin
      active_d  = 1'b1;
      started_d = 1'b0;
      cnt_d     = tcnt_init;
      pos_d     = pos_e'(tpos_init);
      off_d     = '0;
    end
  end

  // Status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      started_q <= started_d;
    end
  end

  // Sequence state, enabled on load or advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= POS_ALL;
      off_q <= '0;
    end else if (load_en || adv_en) begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
      off_q <= off_d;
    end
  end

  // Descriptor constants, loaded once per activation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      total_q <= '0;
    end else if (load_en && !slot && !boundary) begin
      mask_q  <= ss_mask;
      total_q <= total_len;
    end
  end

endmodule

// File: rtl/iso_split_out.sv
module iso_split_out
  import iso_split_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int CLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              miss,
  input  logic [LEN_W-1:0]  off_in,
  input  logic [CLEN_W-1:0] len_in,
  input  pos_e              pos_in,
  output logic              valid_q,
  output logic              miss_q,
  output logic [LEN_W-1:0]  off_q,
  output logic [CLEN_W-1:0] len_q,
  output logic [1:0]        pos_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= issue;
      miss_q  <= miss;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      len_q <= '0;
      pos_q <= 2'b00;
    end else if (issue) begin
      off_q <= off_in;
      len_q <= len_in;
      pos_q <= pos_in;
    end
  end

endmodule

// File: rtl/iso_split_seq.sv
module iso_split_seq
  import iso_split_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 3,
  parameter int UF_N      = 8,
  parameter int CHUNK_MAX = 188,
  localparam int UF_W     = $clog2(UF_N),
  localparam int CLEN_W   = $clog2(CHUNK_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uf_tick,
  input  logic [UF_W-1:0]   uf_idx,
  input  logic              act_req,
  input  logic [UF_N-1:0]   ss_mask,
  input  logic [UF_N-1:0]   cs_mask,
  input  logic [CNT_W-1:0]  tcnt_init,
  input  logic [1:0]        tpos_init,
  input  logic [LEN_W-1:0]  total_len,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [LEN_W-1:0]  out_off,
  output logic [CLEN_W-1:0] out_len,
  output logic [1:0]        out_pos,
  output logic              missed,
  output logic              active
);

  logic [CNT_W-1:0]  cnt_q;
  pos_e              pos_q;
  pos_e              pos_next;
  logic [LEN_W-1:0]  off_q;
  logic [LEN_W-1:0]  total_q;
  logic [UF_N-1:0]   slot_mask;
  logic [LEN_W-1:0]  step;
  logic [CLEN_W-1:0] len;
  logic              issue;
  logic              miss;

  iso_split_desc #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .UF_N(UF_N), .UF_W(UF_W)
  ) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .uf_tick  (uf_tick),
    .uf_idx   (uf_idx),
    .act_req  (act_req),
    .ss_mask  (ss_mask),
    .cs_mask  (cs_mask),
    .tcnt_init(tcnt_init),
    .tpos_init(tpos_init),
    .total_len(total_len),
    .out_ready(out_ready),
    .step     (step),
    .pos_next (pos_next),
    .active_q (active),
    .cnt_q    (cnt_q),
    .pos_q    (pos_q),
    .off_q    (off_q),
    .total_q  (total_q),
    .mask_q   (slot_mask),
    .issue    (issue),
    .miss     (miss)
  );

  iso_split_chunk #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .CHUNK_MAX(CHUNK_MAX), .CLEN_W(CLEN_W)
  ) u_chunk (
    .total_q (total_q),
    .off_q   (off_q),
    .cnt_q   (cnt_q),
    .pos_q   (pos_q),
    .step    (step),
    .len     (len),
    .pos_next(pos_next)
  );

  iso_split_out #(
    .LEN_W(LEN_W), .CLEN_W(CLEN_W)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .miss   (miss),
    .off_in (off_q),
    .len_in (len),
    .pos_in (pos_q),
    .valid_q(out_valid),
    .miss_q (missed),
    .off_q  (out_off),
    .len_q  (out_len),
    .pos_q  (out_pos)
  );

endmodule

// File: rtl/iso_split_chk.sv
module iso_split_chk #(
  parameter int LEN_W     = 11,
  parameter int UF_N      = 8,
  parameter int UF_W      = 3,
  parameter int CLEN_W    = 8,
  parameter int CHUNK_MAX = 188
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uf_tick,
  input logic [UF_W-1:0]   uf_idx,
  input logic [UF_N-1:0]   ss_mask,
  input logic [UF_N-1:0]   cs_mask,
  input logic [UF_N-1:0]   slot_mask,
  input logic              out_valid,
  input logic [CLEN_W-1:0] out_len,
  input logic [1:0]        out_pos,
  input logic              missed,
  input logic              active
);

  // R1: a piece never exceeds the start-split payload limit
  a_r1_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len <= CLEN_W'(CHUNK_MAX)));

  // R3: a piece follows a tick on a selected micro-frame
  a_r3_masked_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(uf_tick) && $past(slot_mask[uf_idx])));

  // R4: an end or all piece closes the descriptor
  a_r4_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_pos == 2'b11 || out_pos == 2'b00)) |-> !active);

  // R6: a missed pulse never comes with a piece and leaves the block idle
  a_r6_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    missed |-> (!out_valid && !active));

  // R8: activation never accepted with a micro-frame 1 clash
  a_r8_uf1_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !($past(ss_mask[1]) && $past(cs_mask[1])));

endmodule

bind iso_split_seq iso_split_chk #(
  .LEN_W(LEN_W), .UF_N(UF_N), .UF_W(UF_W), .CLEN_W(CLEN_W), .CHUNK_MAX(CHUNK_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .uf_tick  (uf_tick),
  .uf_idx   (uf_idx),
  .ss_mask  (ss_mask),
  .cs_mask  (cs_mask),
  .slot_mask(slot_mask),
  .out_valid(out_valid),
  .out_len  (out_len),
  .out_pos  (out_pos),
  .missed   (missed),
  .active   (active)
);

// File: tb/tb_iso_split_seq.sv
module tb_iso_split_seq;

  logic        clk;
  logic        rst_n;
  logic        uf_tick;
  logic [2:0]  uf_idx;
  logic        act_req;
  logic [7:0]  ss_mask;
  logic [7:0]  cs_mask;
  logic [2:0]  tcnt_init;
  logic [1:0]  tpos_init;
  logic [10:0] total_len;
  logic        out_ready;
  logic        out_valid;
  logic [10:0] out_off;
  logic [7:0]  out_len;
  logic [1:0]  out_pos;
  logic        missed;
  logic        active;

  int n_run;
  int n_fail;
  bit done;

  iso_split_seq dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  mask;
    logic [2:0]  cnt;
    logic [1:0]  pos;
    logic [10:0] len;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{mask: 8'h0F, cnt: 3'd1, pos: 2'b00, len: 11'd100},
    '{mask: 8'h3C, cnt: 3'd4, pos: 2'b01, len: 11'd700},
    '{mask: 8'h06, cnt: 3'd2, pos: 2'b01, len: 11'd376},
    '{mask: 8'h80, cnt: 3'd1, pos: 2'b00, len: 11'd0},
    '{mask: 8'h55, cnt: 3'd3, pos: 2'b01, len: 11'd400}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic activate(input logic [7:0] m, input logic [7:0] c, input logic [2:0] n,
                          input logic [1:0] p, input logic [10:0] l);
    @(negedge clk);
    ss_mask = m; cs_mask = c; tcnt_init = n; tpos_init = p; total_len = l;
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
  endtask

  // Outputs registered at the edge inside the tick cycle, read at the next negedge
  task automatic do_tick(input int u);
    @(negedge clk);
    uf_tick = 1'b1; uf_idx = 3'(u);
    @(negedge clk);
    uf_tick = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; uf_tick = 1'b0; uf_idx = '0; act_req = 1'b0;
    ss_mask = '0; cs_mask = '0; tcnt_init = '0; tpos_init = '0; total_len = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(!active && !out_valid && !missed, "R10 reset outputs", active, 0);

    // Vector table: one frame per entry, ready held high
    for (int v = 0; v < NV; v++) begin
      int k;
      k = 0;
      activate(VECS[v].mask, 8'h00, VECS[v].cnt, VECS[v].pos, VECS[v].len);
      check(active, "R4 activation", active, 1);
      for (int u = 0; u < 8; u++) begin
        bit exp_v;
        int exp_off, exp_len, exp_pos;
        exp_v = VECS[v].mask[u] && (k < int'(VECS[v].cnt));
        exp_off = 188 * k;
        exp_len = (int'(VECS[v].len) - exp_off > 188) ? 188 : int'(VECS[v].len) - exp_off;
        if (VECS[v].pos == 2'b00) exp_pos = 0;
        else if (k == 0) exp_pos = 1;
        else if (k == int'(VECS[v].cnt) - 1) exp_pos = 3;
        else exp_pos = 2;
        do_tick(u);
        check(out_valid == exp_v, "R3 valid on masked slot", out_valid, exp_v);
        if (exp_v) begin
          check(out_off == 11'(exp_off), "R1 offset", out_off, exp_off);
          check(out_len == 8'(exp_len), "R1 R5 length", out_len, exp_len);
          check(out_pos == 2'(exp_pos), "R2 position code", out_pos, exp_pos);
          k++;
        end
      end
      check(!active, "R4 inactive after count", active, 0);
    end

    // R6: ready low on a scheduled slot
    activate(8'h0C, 8'h00, 3'd2, 2'b01, 11'd300);
    do_tick(2);
    check(out_valid && out_pos == 2'b01, "R6 first piece", out_pos, 1);
    out_ready = 1'b0;
    do_tick(3);
    check(missed && !out_valid, "R6 missed pulse", missed, 1);
    check(!active, "R6 active cleared", active, 0);
    out_ready = 1'b1;
    do_tick(2);
    check(!out_valid, "R6 no later piece", out_valid, 0);

    // R7: frame boundary coincides with a masked slot at micro-frame 0
    activate(8'h81, 8'h00, 3'd2, 2'b01, 11'd300);
    do_tick(7);
    check(out_valid && out_len == 8'd188, "R7 piece at uf7", out_len, 188);
    do_tick(0);
    check(missed && !out_valid, "R7 boundary miss", out_valid, 0);
    check(!active, "R7 active cleared", active, 0);

    // R8: refused activations
    activate(8'h02, 8'h02, 3'd1, 2'b00, 11'd50);
    check(!active, "R8 uf1 clash refused", active, 0);
    activate(8'h02, 8'h00, 3'd0, 2'b00, 11'd50);
    check(!active, "R8 zero count refused", active, 0);
    activate(8'h02, 8'h01, 3'd1, 2'b00, 11'd50);
    check(active, "R8 no clash accepted", active, 1);
    do_tick(1);
    check(out_valid && out_len == 8'd50 && out_pos == 2'b00, "R8 all piece", out_len, 50);

    // R9: second activation ignored; R6 ready low on unscheduled tick
    activate(8'h30, 8'h00, 3'd2, 2'b01, 11'd200);
    activate(8'h01, 8'h00, 3'd1, 2'b00, 11'd10);
    out_ready = 1'b0;
    do_tick(1);
    check(!missed && active, "R6 unscheduled ready low", missed, 0);
    out_ready = 1'b1;
    do_tick(0);
    check(!out_valid, "R9 new mask ignored", out_valid, 0);
    do_tick(4);
    check(out_valid && out_len == 8'd188 && out_pos == 2'b01, "R9 begin kept", out_len, 188);
    do_tick(5);
    check(out_valid && out_off == 11'd188 && out_len == 8'd12 && out_pos == 2'b11,
          "R9 end kept", out_len, 12);
    check(!active, "R4 end clears active", active, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule